// File: doc/BRIEF.md
# Operation Graph Checking FSM

This block follows a single tagged operation as it moves through a set of functional units. The event pulses it receives are already filtered for its own operation identifier. When the operation starts, an operation-type code comes with the first event. The block walks a fixed directed graph of subtask states and returns to idle when the operation completes. The graph is shared by three operation types, and each type has its own legal event sequence.

Any event that is out of order, repeated, foreign to the latched type, or arriving together with another event drives the machine into a sticky error state. The machine therefore checks the protocol while it traces the operation. The block reports:

- its state code;
- a strobe on every state change, so a trace unit can record transitions only;
- a completion strobe;
- an error strobe;
- a timeout strobe from a programmable stall counter, which catches an expected event that never arrives.

A larger design instantiates one copy per outstanding operation identifier.

Top module: `opgraph_monitor`

## Requirements
- R1: After asynchronous reset, state_o is 0 (idle) and state_chg_o, done_o, err_o and timeout_o are all 0.
- R2: Event bits are evt_i[0]=A, [1]=B, [2]=C, [3]=D, [4]=E, [5]=F, [6]=G. State codes are: idle 0, S0 1, S1 2, S2 3, S3 4, error 7. Type 1 (op_type_i=1) moves idle→S0→S3→idle on A, C, G.
- R3: Type 2 moves idle→S0→S1→S3→idle on A, B, D, G.
- R4: Type 3 moves idle→S0→S1→S2→S3→idle on A, B, E, F, G.
- R5: A single event that is not the one legal event for the current state and latched type moves the machine to error (code 7), with err_o high for exactly one cycle. In idle, this applies to any event other than A.
- R6: The type is taken from op_type_i when A is accepted in idle, and later changes of op_type_i are ignored until the machine is back in idle. Event A with op_type_i=0 is illegal and goes to error.
- R7: Two or more event bits high in the same cycle, in any state other than error, move the machine to error.
- R8: Error is held, and events are ignored, until clear_i is high. clear_i then returns the machine to idle. clear_i has no effect in any other state.
- R9: state_chg_o is high for one cycle exactly when state_o differs from its value in the previous cycle. done_o is high for one cycle when state_o goes from S3 to idle.
- R10: If stall_limit_i=L is nonzero, a non-idle, non-error state that sees no event for L+1 cycles goes to error, with timeout_o and err_o high. An event in that last cycle takes priority over the timeout. L=0 disables the timeout, and idle never times out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 7 | Event pulses for this operation, one bit per event |
| op_type_i | input | 2 | Operation type, sampled with event A |
| clear_i | input | 1 | Synchronous clear out of the error state |
| stall_limit_i | input | STALL_W | Stall limit in cycles, 0 disables |
| state_o | output | 3 | Current state code |
| state_chg_o | output | 1 | State changed at the last edge |
| done_o | output | 1 | Operation completed (S3 to idle) |
| err_o | output | 1 | Error state entered |
| timeout_o | output | 1 | Error caused by a stall timeout |

## Verification
Every output is registered. Each result appears right after the clock edge that samples the event, clear or expiring counter, so the bench drives each stimulus on a falling edge and samples 1 ns after the next rising edge. The sweep covers every type, every position along the type's legal path and every single event. For each case the bench computes the expected state and strobes from the path tables at that one sample point. The stall checks count L+1 quiet cycles after entry to a state: state_o stays put for the first L samples, and the error with timeout_o appears at sample L+1.

// File: rtl/opg_pkg.sv
package opg_pkg;
  localparam int unsigned EVT_N  = 7;
  localparam int unsigned TYPE_W = 2;

  typedef logic [EVT_N-1:0]  evt_vec_t;
  typedef logic [TYPE_W-1:0] op_type_t;

  localparam int unsigned EV_A = 0;
  localparam int unsigned EV_B = 1;
  localparam int unsigned EV_C = 2;
  localparam int unsigned EV_D = 3;
  localparam int unsigned EV_E = 4;
  localparam int unsigned EV_F = 5;
  localparam int unsigned EV_G = 6;

  localparam evt_vec_t EVM_A = evt_vec_t'(1) << EV_A;
  localparam evt_vec_t EVM_B = evt_vec_t'(1) << EV_B;
  localparam evt_vec_t EVM_C = evt_vec_t'(1) << EV_C;
  localparam evt_vec_t EVM_D = evt_vec_t'(1) << EV_D;
  localparam evt_vec_t EVM_E = evt_vec_t'(1) << EV_E;
  localparam evt_vec_t EVM_F = evt_vec_t'(1) << EV_F;
  localparam evt_vec_t EVM_G = evt_vec_t'(1) << EV_G;

  localparam op_type_t OP_NONE = op_type_t'(0);
  localparam op_type_t OP_T1   = op_type_t'(1);
  localparam op_type_t OP_T2   = op_type_t'(2);
  localparam op_type_t OP_T3   = op_type_t'(3);

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_S0   = 3'd1,
    ST_S1   = 3'd2,
    ST_S2   = 3'd3,
    ST_S3   = 3'd4,
    ST_ERR  = 3'd7
  } opg_state_e;
endpackage

// File: rtl/opg_graph_step.sv
module opg_graph_step
  import opg_pkg::*;
(
  input  opg_state_e state_i,
  input  op_type_t   type_q_i,
  input  op_type_t   type_in_i,
  input  evt_vec_t   evt_i,
  input  logic       expired_i,
  input  logic       clear_i,
  output opg_state_e nxt_o,
  output op_type_t   type_nxt_o,
  output logic       tmo_o
);
  evt_vec_t   want;
  opg_state_e tgt;

  // the single legal event and its target for (state, type)
  always_comb begin
    want = '0;
    tgt  = ST_ERR;
    case (state_i)
      ST_IDLE: if (type_in_i != OP_NONE) begin want = EVM_A; tgt = ST_S0; end
      ST_S0: begin
        if (type_q_i == OP_T1) begin
          want = EVM_C; tgt = ST_S3;
        end else if (type_q_i == OP_T2 || type_q_i == OP_T3) begin
          want = EVM_B; tgt = ST_S1;
        end
      end
      ST_S1: begin
        if (type_q_i == OP_T2) begin
          want = EVM_D; tgt = ST_S3;
        end else if (type_q_i == OP_T3) begin
          want = EVM_E; tgt = ST_S2;
        end
      end
      ST_S2: if (type_q_i == OP_T3) begin want = EVM_F; tgt = ST_S3; end
      ST_S3: begin want = EVM_G; tgt = ST_IDLE; end
      default: ;
    endcase
  end

  always_comb begin
    nxt_o      = state_i;
    type_nxt_o = type_q_i;
    tmo_o      = 1'b0;
    if (state_i == ST_ERR) begin
      if (clear_i) begin
        nxt_o      = ST_IDLE;
        type_nxt_o = OP_NONE;
      end
    end else if (evt_i != '0) begin
      // want is one-hot or zero, so simultaneous events never match
      if (want != '0 && evt_i == want) begin
        nxt_o = tgt;
        if (state_i == ST_IDLE) type_nxt_o = type_in_i;
        if (tgt == ST_IDLE)     type_nxt_o = OP_NONE;
      end else begin
        nxt_o = ST_ERR;
      end
    end else if (expired_i) begin
      nxt_o = ST_ERR;
      tmo_o = 1'b1;
    end
  end

  always_comb begin
    if (tmo_o) assert_tmo_quiet_R10: assert (evt_i == '0);
  end
endmodule

// File: rtl/opg_stall_timer.sv
module opg_stall_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (restart_i || !active_i) cnt_q <= '0;
    else if (cnt_q != CNT_MAX)       cnt_q <= cnt_q + CNT_W'(1);
  end

  assign expired_o = (limit_i != '0) && (cnt_q >= limit_i);

  assert_cnt_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> cnt_q == '0);
endmodule

// File: rtl/opgraph_monitor.sv
module opgraph_monitor
  import opg_pkg::*;
#(
  parameter int unsigned STALL_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [EVT_N-1:0]   evt_i,
  input  logic [TYPE_W-1:0]  op_type_i,
  input  logic               clear_i,
  input  logic [STALL_W-1:0] stall_limit_i,
  output logic [2:0]         state_o,
  output logic               state_chg_o,
  output logic               done_o,
  output logic               err_o,
  output logic               timeout_o
);
  opg_state_e state_q, nxt;
  op_type_t   type_q, type_nxt;
  logic       tmo_d, expired, active, restart;
  logic       chg_q, done_q, err_q, tmo_q;

  assign active  = (state_q != ST_IDLE) && (state_q != ST_ERR);
  assign restart = (nxt != state_q);

  opg_graph_step u_step (
    .state_i    (state_q),
    .type_q_i   (type_q),
    .type_in_i  (op_type_i),
    .evt_i      (evt_i),
    .expired_i  (expired),
    .clear_i    (clear_i),
    .nxt_o      (nxt),
    .type_nxt_o (type_nxt),
    .tmo_o      (tmo_d)
  );

  opg_stall_timer #(.CNT_W(STALL_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (active),
    .restart_i (restart),
    .limit_i   (stall_limit_i),
    .expired_o (expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      type_q  <= OP_NONE;
      chg_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= nxt;
      type_q  <= type_nxt;
      chg_q   <= restart;
      done_q  <= (state_q == ST_S3) && (nxt == ST_IDLE);
      err_q   <= (state_q != ST_ERR) && (nxt == ST_ERR);
      tmo_q   <= tmo_d;
    end
  end

  assign state_o     = state_q;
  assign state_chg_o = chg_q;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign timeout_o   = tmo_q;

  assert_err_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ERR && !clear_i) |=> state_q == ST_ERR);

  assert_multi_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_ERR && $countones(evt_i) > 1) |=> state_q == ST_ERR);

  assert_err_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  assert_done_src_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (state_q == ST_IDLE && $past(state_q) == ST_S3));

  assert_type_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active |=> (state_q == ST_IDLE || state_q == ST_ERR || $stable(type_q)));

  assert_tmo_err_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (err_o && state_q == ST_ERR));
endmodule

// File: tb/opgraph_monitor_tb_top.sv
module opgraph_monitor_tb_top;
  localparam int ST_IDLE = 0, ST_S0 = 1, ST_S1 = 2, ST_S2 = 3, ST_S3 = 4, ST_ERR = 7;
  localparam int A = 0, B = 1, C = 2, D = 3, E = 4, F = 5, G = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] evt = '0;
  logic [1:0] optype = '0;
  logic       clr = 1'b0;
  logic [7:0] limit = '0;
  logic [2:0] state;
  logic       chg, done, err, tmo;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  opgraph_monitor #(.STALL_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .op_type_i(optype), .clear_i(clr),
    .stall_limit_i(limit), .state_o(state), .state_chg_o(chg), .done_o(done),
    .err_o(err), .timeout_o(tmo)
  );

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic expect_out(input string rq, input int st, input int c, input int dn,
                            input int er, input int to);
    chk(rq, "state_o", int'(state), st);
    chk(rq, "state_chg_o", int'(chg), c);
    chk(rq, "done_o", int'(done), dn);
    chk(rq, "err_o", int'(err), er);
    chk(rq, "timeout_o", int'(tmo), to);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; evt = '0; clr = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input logic [6:0] ev, input logic [1:0] ty, input bit cl);
    @(negedge clk);
    evt = ev; optype = ty; clr = cl;
    @(posedge clk);
    #1;
    evt = '0; clr = 1'b0;
  endtask

  function automatic int path_len(input int t);
    return t + 2;
  endfunction

  function automatic int path_evt(input int t, input int k);
    case (t)
      1: case (k) 0: return A; 1: return C; default: return G; endcase
      2: case (k) 0: return A; 1: return B; 2: return D; default: return G; endcase
      default: case (k) 0: return A; 1: return B; 2: return E; 3: return F; default: return G; endcase
    endcase
  endfunction

  function automatic int path_state(input int t, input int k);
    case (t)
      1: case (k) 0: return ST_S0; 1: return ST_S3; default: return ST_IDLE; endcase
      2: case (k) 0: return ST_S0; 1: return ST_S1; 2: return ST_S3; default: return ST_IDLE; endcase
      default: case (k) 0: return ST_S0; 1: return ST_S1; 2: return ST_S2; 3: return ST_S3; default: return ST_IDLE; endcase
    endcase
  endfunction

  function automatic string type_req(input int t);
    return (t == 1) ? "R2" : (t == 2) ? "R3" : "R4";
  endfunction

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset();
    #1;
    expect_out("R1", ST_IDLE, 0, 0, 0, 0);

    // sweep: every type, every path position, every single event (R2 R3 R4 R5)
    for (int t = 1; t <= 3; t++) begin
      for (int k = 0; k < path_len(t); k++) begin
        for (int e = 0; e < 7; e++) begin
          bit legal;
          int exp_st;
          do_reset();
          for (int j = 0; j < k; j++) begin
            step(7'(1) << path_evt(t, j), 2'(t), 1'b0);
            chk(type_req(t), "path state", int'(state), path_state(t, j));
          end
          step(7'(1) << e, 2'(t), 1'b0);
          legal  = (e == path_evt(t, k));
          exp_st = legal ? path_state(t, k) : ST_ERR;
          expect_out(legal ? type_req(t) : "R5", exp_st, 1,
                     (legal && k == path_len(t) - 1) ? 1 : 0, legal ? 0 : 1, 0);
          if (!legal) begin
            step('0, 2'(t), 1'b0);
            chk("R5", "err_o pulse width", int'(err), 0);
          end
        end
      end
    end

    // R6 type zero is illegal
    do_reset();
    step(7'(1) << A, 2'd0, 1'b0);
    expect_out("R6", ST_ERR, 1, 0, 1, 0);

    // R6 type latched: op_type_i change after A is ignored
    do_reset();
    step(7'(1) << A, 2'd1, 1'b0);
    step('0, 2'd2, 1'b0);
    chk("R6", "state after type change", int'(state), ST_S0);
    step(7'(1) << B, 2'd2, 1'b0);
    expect_out("R6", ST_ERR, 1, 0, 1, 0);
    do_reset();
    step(7'(1) << A, 2'd1, 1'b0);
    step(7'(1) << C, 2'd3, 1'b0);
    expect_out("R6", ST_S3, 1, 0, 0, 0);

    // R7 simultaneous events
    do_reset();
    step((7'(1) << A) | (7'(1) << B), 2'd3, 1'b0);
    expect_out("R7", ST_ERR, 1, 0, 1, 0);
    do_reset();
    step(7'(1) << A, 2'd3, 1'b0);
    step(7'(1) << B, 2'd3, 1'b0);
    step((7'(1) << E) | (7'(1) << F), 2'd3, 1'b0);
    expect_out("R7", ST_ERR, 1, 0, 1, 0);
    do_reset();
    step(7'(1) << A, 2'd1, 1'b0);
    step((7'(1) << A) | (7'(1) << C), 2'd1, 1'b0);
    expect_out("R7", ST_ERR, 1, 0, 1, 0);

    // R8 sticky error, events ignored, clear
    step(7'(1) << G, 2'd1, 1'b0);
    expect_out("R8", ST_ERR, 0, 0, 0, 0);
    step(7'h7f, 2'd1, 1'b0);
    expect_out("R8", ST_ERR, 0, 0, 0, 0);
    step('0, 2'd1, 1'b1);
    expect_out("R8", ST_IDLE, 1, 0, 0, 0);
    step('0, 2'd1, 1'b0);
    expect_out("R9", ST_IDLE, 0, 0, 0, 0);

    // R8 clear ignored outside error
    step(7'(1) << A, 2'd2, 1'b0);
    step('0, 2'd2, 1'b1);
    expect_out("R8", ST_S0, 0, 0, 0, 0);

    // R9 strobes are single-cycle across a full type 2 run
    step(7'(1) << B, 2'd2, 1'b0);
    step('0, 2'd2, 1'b0);
    expect_out("R9", ST_S1, 0, 0, 0, 0);
    step(7'(1) << D, 2'd2, 1'b0);
    step(7'(1) << G, 2'd2, 1'b0);
    expect_out("R9", ST_IDLE, 1, 1, 0, 0);
    step('0, 2'd2, 1'b0);
    expect_out("R9", ST_IDLE, 0, 0, 0, 0);

    // R10 stall timeout with limit 3
    do_reset();
    limit = 8'd3;
    step(7'(1) << A, 2'd1, 1'b0);
    for (int i = 0; i < 3; i++) begin
      step('0, 2'd1, 1'b0);
      expect_out("R10", ST_S0, 0, 0, 0, 0);
    end
    step('0, 2'd1, 1'b0);
    expect_out("R10", ST_ERR, 1, 0, 1, 1);
    step('0, 2'd1, 1'b0);
    expect_out("R10", ST_ERR, 0, 0, 0, 0);
    step('0, 2'd1, 1'b1);

    // R10 event in expiring cycle wins; S3 also times per state
    step(7'(1) << A, 2'd1, 1'b0);
    for (int i = 0; i < 3; i++) step('0, 2'd1, 1'b0);
    step(7'(1) << C, 2'd1, 1'b0);
    expect_out("R10", ST_S3, 1, 0, 0, 0);
    for (int i = 0; i < 3; i++) step('0, 2'd1, 1'b0);
    step(7'(1) << G, 2'd1, 1'b0);
    expect_out("R10", ST_IDLE, 1, 1, 0, 0);

    // R10 idle never times out
    for (int i = 0; i < 10; i++) step('0, 2'd1, 1'b0);
    expect_out("R10", ST_IDLE, 0, 0, 0, 0);

    // R10 limit 0 disables
    limit = 8'd0;
    step(7'(1) << A, 2'd3, 1'b0);
    for (int i = 0; i < 20; i++) step('0, 2'd3, 1'b0);
    expect_out("R10", ST_S0, 0, 0, 0, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule